// File: doc/BRIEF.md
# Dual-Bank Flash Write Status Responder

This block is a clocked model of the read path and write-status logic of a flash device that has two banks. It splits the word address space into a small top bank and a large main bank. For each bank it tracks whether an internally timed erase or program is running. A read of a bank that is not busy returns the stored word. A read of the busy bank returns a status word instead. That status word carries a polling bit, which is the inverse of bit 7 of the reference word, and a bit that alternates on every read. The other bank can be read normally at the same time.

An internal write timer drives the block. The timer raises a one-cycle start pulse on the bank it targets and gives the operation code, the word address and the data word. Later it raises a one-cycle done pulse on the same bank. The array is a small register memory for each bank, and it takes the result of the operation when the done pulse arrives. A ready/busy pin is modelled as a value plus an output enable. A device-identification read is answered only while both banks are idle.

Top module: `dual_bank_status_resp`

## Requirements
- R1: Address bits [19:18] select the bank. If both bits are 1, the top bank is selected (index 1). Every other value selects the main bank (index 0). Within a bank, the word index is address bits [3:0].
- R2: A read strobe in cycle t gives rd_valid_o = 1 and the read word in cycle t+1. Without a strobe, rd_valid_o is 0 and rd_data_o is 0000h, which stands for a released bus.
- R3: A start pulse is accepted only while neither bank is busy, and the bank shows busy from the next cycle. If both start bits are high together, only the main bank starts. A start pulse that arrives while any bank is busy is ignored.
- R4: A read of the busy bank returns a status word. Bit 7 is the inverse of bit 7 of the reference word. The reference word is the write data for operation code 00b (program) and 11b (no-op), and FFFFh for 01b (sector erase) and 10b (bank erase). Bits 15:8 and 5:0 of the status word are 0.
- R5: Bit 6 of the status word is 0 on the first read of the busy bank after its start. It flips on every further read of that bank until the operation ends.
- R6: While one bank is busy, a read of the other bank returns its stored word.
- R7: A done pulse on the busy bank clears its busy state at the next edge, and later reads return array data. A done pulse on an idle bank has no effect.
- R8: Program (00b) stores the old word AND the write data at the word address, when the done pulse arrives.
- R9: Sector erase (01b) sets to FFFFh every word whose address bits [3:2] match the write address. Bank erase (10b) sets every word of the bank to FFFFh. No-op (11b) changes nothing. The array is updated when the done pulse arrives.
- R10: rb_oe_o is 1 exactly while a bank is busy, and rb_o is always 0.
- R11: An identification read (id_rd_i with rd_en_i) while both banks are idle returns 00C3h when address bit 0 is 0. When bit 0 is 1 it returns the device code of the selected bank: 22A1h for the main bank and 22B4h for the top bank. While any bank is busy, it is handled as an ordinary read.
- R12: After reset, every word reads FFFFh, no bank is busy, rd_valid_o is 0 and rb_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe |
| id_rd_i | input | 1 | Makes the read an identification read |
| rd_addr_i | input | 20 | Read word address |
| start_i | input | 2 | Start pulse for each bank (bit 0 main, bit 1 top) |
| done_i | input | 2 | Done pulse for each bank from the write timer |
| wr_op_i | input | 2 | Operation code: 00 program, 01 sector erase, 10 bank erase, 11 no-op |
| wr_addr_i | input | 20 | Word address of the operation |
| wr_data_i | input | 16 | Last word loaded (program data) |
| rd_data_o | output | 16 | Read word, 0 when not valid |
| rd_valid_o | output | 1 | Read data is driven |
| rb_o | output | 1 | Ready/busy value, always low |
| rb_oe_o | output | 1 | Ready/busy pin is driven (busy) |

## Verification
The main function is exercised by reading a bank over and over while it is busy. Three consecutive reads of the busy bank show that the alternating bit steps once per read and not once per cycle, and that the polling bit follows the reference word. The pattern contrasts program data whose bit 7 is 0 with an erase, whose reference bit is 1. Reads of the idle bank are interleaved with those of the busy bank, so the test can tell status substitution apart from a mix-up in bank decode. Identification reads issued during and after a write separate the refusal path from the code path. Start pulses on both banks at once, a start pulse during a busy period, and a done pulse on an idle bank probe the arbitration rules.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic [1:0] {
    OP_PROG       = 2'b00,
    OP_SECT_ERASE = 2'b01,
    OP_BANK_ERASE = 2'b10,
    OP_NONE       = 2'b11
  } op_e;

  // Top bank only when both select bits are set
  function automatic logic top_bank_hit(input logic [1:0] sel);
    return &sel;
  endfunction

  function automatic logic is_erase(input op_e op);
    return (op == OP_SECT_ERASE) || (op == OP_BANK_ERASE);
  endfunction
endpackage

// File: rtl/fbs_bank_ctl.sv
module fbs_bank_ctl
  import fbs_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned MEM_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              rd_hit_i,
  input  op_e               op_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              tog_o,
  output logic              poll_o,
  output logic              commit_o,
  output op_e               c_op_o,
  output logic [MEM_AW-1:0] c_addr_o,
  output logic [WORD_W-1:0] c_data_o
);
  logic              busy_q, tog_q, ref7_q;
  op_e               op_q;
  logic [MEM_AW-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      ref7_q <= 1'b1;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tog_q  <= 1'b0;
      ref7_q <= is_erase(op_i) ? 1'b1 : wdata_i[7];
      op_q   <= op_i;
      addr_q <= waddr_i;
      data_q <= wdata_i;
    end else if (busy_q) begin
      if (rd_hit_i) tog_q <= ~tog_q;
      if (done_i) busy_q <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign tog_o    = tog_q;
  assign poll_o   = ~ref7_q;
  assign commit_o = busy_q & done_i;
  assign c_op_o   = op_q;
  assign c_addr_o = addr_q;
  assign c_data_o = data_q;
endmodule

// File: rtl/fbs_bank_array.sv
module fbs_bank_array
  import fbs_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned MEM_AW  = 4,
  parameter int unsigned SECT_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  op_e               op_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** MEM_AW;

  logic [WORD_W-1:0] mem_w [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [MEM_AW-1:0] WADDR = MEM_AW'(w);
    logic [WORD_W-1:0] word_q;
    logic              word_hit, sect_hit;

    assign word_hit = (addr_i == WADDR);
    assign sect_hit = (addr_i[MEM_AW-1:SECT_AW] == WADDR[MEM_AW-1:SECT_AW]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '1;
      end else if (commit_i) begin
        unique case (op_i)
          OP_PROG:       if (word_hit) word_q <= word_q & data_i;
          OP_SECT_ERASE: if (sect_hit) word_q <= '1;
          OP_BANK_ERASE: word_q <= '1;
          default:       ;
        endcase
      end
    end

    assign mem_w[w] = word_q;
  end

  assign rdata_o = mem_w[raddr_i];
endmodule

// File: rtl/fbs_read_mux.sv
module fbs_read_mux #(
  parameter int unsigned WORD_W     = 16,
  parameter logic [15:0] MAKER_ID   = 16'h00C3,
  parameter logic [15:0] DEV_ID_MAIN = 16'h22A1,
  parameter logic [15:0] DEV_ID_TOP  = 16'h22B4
) (
  input  logic              id_ok_i,
  input  logic              top_i,
  input  logic              addr_lsb_i,
  input  logic              busy_i,
  input  logic              poll_i,
  input  logic              tog_i,
  input  logic [WORD_W-1:0] arr_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = arr_i;
    if (id_ok_i) begin
      if (!addr_lsb_i)  word_o = WORD_W'(MAKER_ID);
      else if (top_i)   word_o = WORD_W'(DEV_ID_TOP);
      else              word_o = WORD_W'(DEV_ID_MAIN);
    end else if (busy_i) begin
      word_o    = '0;
      word_o[7] = poll_i;
      word_o[6] = tog_i;
    end
  end
endmodule

// File: rtl/dual_bank_status_resp.sv
module dual_bank_status_resp
  import fbs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned MEM_AW      = 4,
  parameter int unsigned SECT_AW     = 2,
  parameter logic [15:0] MAKER_ID    = 16'h00C3,
  parameter logic [15:0] DEV_ID_MAIN = 16'h22A1,
  parameter logic [15:0] DEV_ID_TOP  = 16'h22B4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              id_rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [1:0]        start_i,
  input  logic [1:0]        done_i,
  input  logic [1:0]        wr_op_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rb_o,
  output logic              rb_oe_o
);
  logic [NUM_BANKS-1:0] busy_q, start_acc, rd_hit, tog_w, poll_w, commit_w;
  op_e                  c_op   [NUM_BANKS];
  logic [MEM_AW-1:0]    c_addr [NUM_BANKS];
  logic [WORD_W-1:0]    c_data [NUM_BANKS];
  logic [WORD_W-1:0]    arr_rd [NUM_BANKS];
  logic                 rd_bank, any_busy, id_ok;
  logic [WORD_W-1:0]    rd_word, rd_data_q;
  logic                 rd_valid_q;
  logic                 unused_addr;

  assign rd_bank  = top_bank_hit(rd_addr_i[ADDR_W-1 -: 2]);
  assign any_busy = |busy_q;
  assign id_ok    = id_rd_i & ~any_busy;

  // Main bank wins a simultaneous start; nothing starts while busy
  assign start_acc[0] = start_i[0] & ~any_busy;
  assign start_acc[1] = start_i[1] & ~start_i[0] & ~any_busy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign rd_hit[b] = rd_en_i & ~id_ok & (rd_bank == b[0]);

    fbs_bank_ctl #(.WORD_W(WORD_W), .MEM_AW(MEM_AW)) u_ctl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_acc[b]),
      .done_i   (done_i[b]),
      .rd_hit_i (rd_hit[b]),
      .op_i     (op_e'(wr_op_i)),
      .waddr_i  (wr_addr_i[MEM_AW-1:0]),
      .wdata_i  (wr_data_i),
      .busy_o   (busy_q[b]),
      .tog_o    (tog_w[b]),
      .poll_o   (poll_w[b]),
      .commit_o (commit_w[b]),
      .c_op_o   (c_op[b]),
      .c_addr_o (c_addr[b]),
      .c_data_o (c_data[b])
    );

    fbs_bank_array #(.WORD_W(WORD_W), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW)) u_arr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (commit_w[b]),
      .op_i     (c_op[b]),
      .addr_i   (c_addr[b]),
      .data_i   (c_data[b]),
      .raddr_i  (rd_addr_i[MEM_AW-1:0]),
      .rdata_o  (arr_rd[b])
    );
  end

  fbs_read_mux #(
    .WORD_W(WORD_W), .MAKER_ID(MAKER_ID),
    .DEV_ID_MAIN(DEV_ID_MAIN), .DEV_ID_TOP(DEV_ID_TOP)
  ) u_mux (
    .id_ok_i    (id_ok),
    .top_i      (rd_bank),
    .addr_lsb_i (rd_addr_i[0]),
    .busy_i     (busy_q[rd_bank]),
    .poll_i     (poll_w[rd_bank]),
    .tog_i      (tog_w[rd_bank]),
    .arr_i      (arr_rd[rd_bank]),
    .word_o     (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      rd_data_q  <= rd_en_i ? rd_word : '0;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign rb_o        = 1'b0;
  assign rb_oe_o     = any_busy;
  assign unused_addr = ^{rd_addr_i[ADDR_W-3:MEM_AW], wr_addr_i[ADDR_W-1:MEM_AW]};
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              id_rd_i,
  input logic              rd_bank_i,
  input logic [1:0]        start_i,
  input logic [1:0]        done_i,
  input logic [1:0]        busy_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              rb_oe_o
);
  AST_BUSY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_i)); // R3
  AST_TOP_START_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i[0] |=> !busy_i[1]); // R3
  AST_MAIN_START_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i[1] |=> !busy_i[0]); // R3
  AST_MAIN_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i[0] && done_i[0]) |=> !busy_i[0]); // R7
  AST_TOP_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i[1] && done_i[1]) |=> !busy_i[1]); // R7
  AST_VALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R2
  AST_RELEASED_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0)); // R2
  AST_STATUS_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_i[rd_bank_i]) |=>
      (rd_data_o[WORD_W-1:8] == '0 && rd_data_o[5:0] == '0)); // R4
  AST_RB_RISE_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rb_oe_o) |-> $past(|start_i)); // R10

  logic unused_chk;
  assign unused_chk = id_rd_i;
endmodule

bind dual_bank_status_resp fbs_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .id_rd_i    (id_rd_i),
  .rd_bank_i  (rd_bank),
  .start_i    (start_i),
  .done_i     (done_i),
  .busy_i     (busy_q),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .rb_oe_o    (rb_oe_o)
);

// File: tb/dual_bank_status_resp_tb_top.sv
`timescale 1ns/1ps
module dual_bank_status_resp_tb_top;
  localparam logic [15:0] MAKER = 16'h00C3;
  localparam logic [15:0] DEVM  = 16'h22A1;
  localparam logic [15:0] DEVT  = 16'h22B4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rd_en = 0, id_rd = 0;
  logic [19:0] rd_addr = '0, wr_addr = '0;
  logic [1:0]  start = '0, done = '0, wr_op = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        rd_valid, rb, rb_oe;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R12";

  // reference model state
  logic [15:0] m_mem [2][16];
  bit          m_busy [2];
  bit          m_tog [2];
  logic [15:0] m_ref [2];
  logic [1:0]  m_op [2];
  logic [3:0]  m_addr [2];
  logic [15:0] m_data [2];
  logic [15:0] exp_data = '0;
  bit          exp_valid = 0;

  always #2.5 clk = ~clk;

  dual_bank_status_resp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .id_rd_i(id_rd),
    .rd_addr_i(rd_addr), .start_i(start), .done_i(done), .wr_op_i(wr_op),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rb_o(rb), .rb_oe_o(rb_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic commit(input int k);
    case (m_op[k])
      2'b00: m_mem[k][m_addr[k]] = m_mem[k][m_addr[k]] & m_data[k];
      2'b01: for (int i = 0; i < 16; i++)
               if (i[3:2] == m_addr[k][3:2]) m_mem[k][i] = 16'hFFFF;
      2'b10: for (int i = 0; i < 16; i++) m_mem[k][i] = 16'hFFFF;
      default: ;
    endcase
  endtask

  task automatic model_edge();
    int b;
    bit anyb, idok;
    b    = (rd_addr[19:18] == 2'b11) ? 1 : 0;
    anyb = m_busy[0] | m_busy[1];
    idok = id_rd && !anyb;
    exp_valid = rd_en;
    if (!rd_en)           exp_data = 16'h0000;
    else if (idok)        exp_data = !rd_addr[0] ? MAKER : (b == 1 ? DEVT : DEVM);
    else if (m_busy[b])   exp_data = {8'h00, ~m_ref[b][7], m_tog[b], 6'h00};
    else                  exp_data = m_mem[b][rd_addr[3:0]];
    for (int k = 0; k < 2; k++) begin
      if (m_busy[k]) begin
        if (rd_en && !idok && b == k) m_tog[k] = ~m_tog[k];
        if (done[k]) begin commit(k); m_busy[k] = 0; end
      end
    end
    if (!anyb && start != 2'b00) begin
      int k;
      k = start[0] ? 0 : 1;
      m_busy[k] = 1; m_tog[k] = 0; m_op[k] = wr_op;
      m_addr[k] = wr_addr[3:0]; m_data[k] = wr_data;
      m_ref[k]  = (wr_op == 2'b01 || wr_op == 2'b10) ? 16'hFFFF : wr_data;
    end
  endtask

  task automatic cyc(input bit r, input bit id, input logic [19:0] ra,
                     input logic [1:0] st, input logic [1:0] dn,
                     input logic [1:0] op, input logic [19:0] wa,
                     input logic [15:0] wd);
    rd_en = r; id_rd = id; rd_addr = ra; start = st; done = dn;
    wr_op = op; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(cur_req, "rd_valid", {15'd0, rd_valid}, {15'd0, exp_valid});
    chk(cur_req, "rd_data", rd_data, exp_data);
    chk("R10", "rb_oe", {15'd0, rb_oe}, {15'd0, m_busy[0] | m_busy[1]});
    chk("R10", "rb", {15'd0, rb}, 16'h0000);
  endtask

  task automatic rd(input logic [19:0] a);  cyc(1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic idr(input logic [19:0] a); cyc(1, 1, a, 0, 0, 0, 0, 0); endtask
  task automatic idle();                     cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic go(input logic [1:0] st, input logic [1:0] op,
                    input logic [19:0] wa, input logic [15:0] wd);
    cyc(0, 0, 0, st, 0, op, wa, wd);
  endtask
  task automatic fin(input logic [1:0] dn); cyc(0, 0, 0, 0, dn, 0, 0, 0); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 50000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL R7 watchdog actual=%0d cycles expected < 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_busy[k] = 0; m_tog[k] = 0; m_ref[k] = 16'hFFFF;
      m_op[k] = 2'b11; m_addr[k] = '0; m_data[k] = '0;
      for (int i = 0; i < 16; i++) m_mem[k][i] = 16'hFFFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    cur_req = "R12";
    chk("R12", "rd_valid after reset", {15'd0, rd_valid}, 16'h0000);
    chk("R12", "rb_oe after reset", {15'd0, rb_oe}, 16'h0000);
    rd(20'h00005); rd(20'hC0007);
    // R11 / R1: identification codes and bank decode
    cur_req = "R11";
    idr(20'h00000);
    cur_req = "R1";
    idr(20'hC0001); idr(20'h80001); idr(20'h40001);
    // R8 program main bank word 3; R4/R5 status reads
    cur_req = "R8";
    go(2'b01, 2'b00, 20'h00003, 16'h1234);
    cur_req = "R5";
    rd(20'h00003); rd(20'h00003); idle(); rd(20'h00003);
    cur_req = "R6";
    rd(20'hC0003);
    cur_req = "R2";
    idle();
    cur_req = "R11";
    idr(20'h00001); idr(20'hC0001);
    cur_req = "R3";
    go(2'b10, 2'b00, 20'hC0004, 16'h0000);
    rd(20'hC0004);
    cur_req = "R7";
    fin(2'b10); rd(20'h00003);
    fin(2'b01);
    rd(20'h00003); rd(20'hC0004);
    cur_req = "R8";
    go(2'b01, 2'b00, 20'h00003, 16'h00A0);
    rd(20'h00003); fin(2'b01); rd(20'h00003);
    // R3 simultaneous start: main bank wins
    cur_req = "R3";
    go(2'b11, 2'b00, 20'h00002, 16'h5A5A);
    rd(20'h00002); rd(20'hC0002); fin(2'b01); rd(20'h00002); rd(20'hC0002);
    // top bank program while main bank reads normally
    cur_req = "R6";
    go(2'b10, 2'b00, 20'hC0009, 16'h0F0F);
    rd(20'hC0009); rd(20'h00002); rd(20'hC0009);
    cyc(1, 0, 20'hC0009, 0, 2'b10, 0, 0, 0);
    rd(20'hC0009);
    // R9 sector erase on main bank, word 5 outside sector kept
    cur_req = "R9";
    go(2'b01, 2'b00, 20'h00005, 16'h0000); fin(2'b01);
    go(2'b01, 2'b01, 20'h00001, 16'h0000);
    rd(20'h00001); rd(20'h00002); fin(2'b01);
    rd(20'h00002); rd(20'h00003); rd(20'h00005);
    // R9 no-op leaves word untouched
    go(2'b01, 2'b11, 20'h00005, 16'hFFFF); fin(2'b01); rd(20'h00005);
    // R9 bank erase on top bank
    go(2'b10, 2'b10, 20'hC0000, 16'h0000);
    rd(20'hC0009); rd(20'h00005); fin(2'b10);
    rd(20'hC0009); rd(20'hC000F);
    // R4 status with bit7 of data high
    cur_req = "R4";
    go(2'b10, 2'b00, 20'hC000F, 16'h00F0);
    rd(20'hC000F); fin(2'b10); rd(20'hC000F);
    cur_req = "R11";
    idr(20'hC0001);
    idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule